// File: doc/BRIEF.md
# Named Content Cache with Reply Rewrite

This block sits at the tail of a packet pipeline and keeps a small direct-mapped store of named content. Each packet reaches it as a single descriptor per cycle: a kind flag (request or response), a name key, a flag showing whether a nonce field is present, a total length in bytes, a 64-bit content value, the port the packet arrived on and the port it is meant to leave by. One cycle later the block emits the descriptor, which may have been rewritten.

A response descriptor leaves the block unchanged. Its content is also written into slot `key % CAPACITY`, together with the key, and replaces whatever that slot held. A request descriptor is checked against its slot. A hit needs a valid slot whose stored key equals the request key. On a hit the request is turned into a response in place: the kind becomes response, the key is kept, the nonce is removed, the cached content is attached, the length is recomputed and the egress port is set to the ingress port, so the reply returns toward the requester. On a miss the request passes through unchanged so that normal forwarding can send it upstream.

The control is a four-state machine that records what the block will emit in the next cycle. `ST_IDLE` means nothing is emitted. `ST_PASS_RESP` means a response is passed through. `ST_FWD_REQ` means a request that missed is forwarded. `ST_REPLY` means a request that hit is emitted after rewriting. Every cycle the next state is chosen from the current input alone: no valid input gives `ST_IDLE`, a response gives `ST_PASS_RESP`, and a request gives `ST_REPLY` on a hit or `ST_FWD_REQ` on a miss. Any state can move to any other.

Top module: `content_cache_rewrite`

## Requirements
- R1: After reset `out_valid` is 0 and every slot is empty, so a request to any key emitted after reset comes out as a miss.
- R2: Each cycle with `in_valid`=1 produces exactly one output descriptor with `out_valid`=1 in the following cycle. A cycle with `in_valid`=0 gives `out_valid`=0 in the following cycle.
- R3: A response (`in_kind`=1) is emitted with every field unchanged. Its key and content are stored in slot `key % CAPACITY`, and a request in any later cycle can hit on them.
- R4: On a request hit (`in_kind`=0) the output has `out_kind`=1 (response) and the same key as the input.
- R5: On a request hit, `out_nonce`=0, `out_content` is the cached value, and `out_len` = `in_len` − (`in_nonce` ? 2+NONCE_BYTES : 0) + 10. The 10 is the content field: an 8-bit type, an 8-bit length code and a 64-bit value.
- R6: On a request hit, `out_eport` equals `in_iport`. The ingress port is emitted unchanged.
- R7: On a request miss, caused either by an empty slot or by a slot holding a different key, the request is emitted with every field unchanged and `out_kind`=0.
- R8: A response whose key maps to an occupied slot replaces the entry there. A later request for the previous key of that slot then misses, and a request for the new key hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An input descriptor is present this cycle |
| in_kind | input | 1 | 0 = request, 1 = response |
| in_key | input | KEY_W | Name key |
| in_nonce | input | 1 | Nonce field present |
| in_len | input | LEN_W | Packet length in bytes |
| in_content | input | DATA_W | Content value (meaningful on responses) |
| in_iport | input | PORT_W | Port the packet arrived on |
| in_eport | input | PORT_W | Port chosen for departure |
| out_valid | output | 1 | Output descriptor present |
| out_kind | output | 1 | 0 = request, 1 = response |
| out_key | output | KEY_W | Name key |
| out_nonce | output | 1 | Nonce field present |
| out_len | output | LEN_W | Packet length in bytes |
| out_content | output | DATA_W | Content value |
| out_iport | output | PORT_W | Ingress port |
| out_eport | output | PORT_W | Departure port |

## Verification
The assertions assume that reset is held for at least one clock before the first descriptor. They also assume that a request carrying a nonce has `in_len` of at least 2+NONCE_BYTES, so the recomputed length does not wrap. The stimulus keeps every request length at or above that bound and leaves `in_valid` low during reset. It draws keys from a small range that spans more than one multiple of the capacity, so that hits, empty-slot misses and key-collision misses all occur often.

// File: rtl/cc_pkg.sv
package cc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_PASS_RESP = 2'd1,
        ST_FWD_REQ   = 2'd2,
        ST_REPLY     = 2'd3
    } cc_state_e;

    localparam logic KIND_REQ  = 1'b0;
    localparam logic KIND_RESP = 1'b1;

    // content field header: type byte plus length-code byte
    localparam int TLV_HDR_BYTES = 2;
endpackage

// File: rtl/cc_store.sv
module cc_store #(
    parameter int CAPACITY = 16,
    parameter int KEY_W    = 32,
    parameter int DATA_W   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [KEY_W-1:0]  wr_key,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [KEY_W-1:0]  rd_key,
    output logic              rd_hit,
    output logic [DATA_W-1:0] rd_data
);
    localparam int IDX_W = (CAPACITY > 1) ? $clog2(CAPACITY) : 1;

    logic [KEY_W-1:0]  key_mem  [CAPACITY];
    logic [DATA_W-1:0] data_mem [CAPACITY];
    logic [CAPACITY-1:0] slot_ok;

    logic [IDX_W-1:0] wr_idx, rd_idx;
    assign wr_idx = IDX_W'(wr_key % KEY_W'(CAPACITY));
    assign rd_idx = IDX_W'(rd_key % KEY_W'(CAPACITY));

    for (genvar s = 0; s < CAPACITY; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_ok[s] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(s))) begin
                slot_ok[s] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(s))) begin
                key_mem[s]  <= wr_key;
                data_mem[s] <= wr_data;
            end
        end
    end

    assign rd_hit  = slot_ok[rd_idx] && (key_mem[rd_idx] == rd_key);
    assign rd_data = data_mem[rd_idx];
endmodule

// File: rtl/cc_rewrite.sv
module cc_rewrite #(
    parameter int LEN_W       = 16,
    parameter int DATA_W      = 64,
    parameter int PORT_W      = 4,
    parameter int NONCE_BYTES = 4
) (
    input  logic              nonce_in,
    input  logic [LEN_W-1:0]  len_in,
    input  logic [PORT_W-1:0] iport_in,
    input  logic [DATA_W-1:0] cached,
    output logic              kind_out,
    output logic              nonce_out,
    output logic [LEN_W-1:0]  len_out,
    output logic [DATA_W-1:0] content_out,
    output logic [PORT_W-1:0] eport_out
);
    import cc_pkg::*;

    localparam int NONCE_TLV   = TLV_HDR_BYTES + NONCE_BYTES;
    localparam int CONTENT_TLV = TLV_HDR_BYTES + DATA_W / 8;

    logic [LEN_W-1:0] stripped;

    always_comb begin
        stripped    = nonce_in ? (len_in - LEN_W'(NONCE_TLV)) : len_in;
        len_out     = stripped + LEN_W'(CONTENT_TLV);
        kind_out    = KIND_RESP;
        nonce_out   = 1'b0;
        content_out = cached;
        eport_out   = iport_in;
    end
endmodule

// File: rtl/content_cache_rewrite.sv
module content_cache_rewrite #(
    parameter int CAPACITY    = 16,
    parameter int KEY_W       = 32,
    parameter int DATA_W      = 64,
    parameter int LEN_W       = 16,
    parameter int PORT_W      = 4,
    parameter int NONCE_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_kind,
    input  logic [KEY_W-1:0]  in_key,
    input  logic              in_nonce,
    input  logic [LEN_W-1:0]  in_len,
    input  logic [DATA_W-1:0] in_content,
    input  logic [PORT_W-1:0] in_iport,
    input  logic [PORT_W-1:0] in_eport,
    output logic              out_valid,
    output logic              out_kind,
    output logic [KEY_W-1:0]  out_key,
    output logic              out_nonce,
    output logic [LEN_W-1:0]  out_len,
    output logic [DATA_W-1:0] out_content,
    output logic [PORT_W-1:0] out_iport,
    output logic [PORT_W-1:0] out_eport
);
    import cc_pkg::*;

    cc_state_e st_q, st_d;

    logic              lk_hit;
    logic [DATA_W-1:0] lk_data;

    logic              kind_q, nonce_q;
    logic [KEY_W-1:0]  key_q;
    logic [LEN_W-1:0]  len_q;
    logic [DATA_W-1:0] content_q, cached_q;
    logic [PORT_W-1:0] iport_q, eport_q;

    logic              rw_kind, rw_nonce;
    logic [LEN_W-1:0]  rw_len;
    logic [DATA_W-1:0] rw_content;
    logic [PORT_W-1:0] rw_eport;

    cc_store #(
        .CAPACITY (CAPACITY),
        .KEY_W    (KEY_W),
        .DATA_W   (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (in_valid && (in_kind == KIND_RESP)),
        .wr_key  (in_key),
        .wr_data (in_content),
        .rd_key  (in_key),
        .rd_hit  (lk_hit),
        .rd_data (lk_data)
    );

    // next state from the current input
    always_comb begin
        st_d = ST_IDLE;
        if (in_valid) begin
            unique case (in_kind)
                KIND_RESP: st_d = ST_PASS_RESP;
                KIND_REQ:  st_d = lk_hit ? ST_REPLY : ST_FWD_REQ;
                default:   st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // captured descriptor
    always_ff @(posedge clk) begin
        if (in_valid) begin
            kind_q    <= in_kind;
            key_q     <= in_key;
            nonce_q   <= in_nonce;
            len_q     <= in_len;
            content_q <= in_content;
            iport_q   <= in_iport;
            eport_q   <= in_eport;
            cached_q  <= lk_data;
        end
    end

    cc_rewrite #(
        .LEN_W       (LEN_W),
        .DATA_W      (DATA_W),
        .PORT_W      (PORT_W),
        .NONCE_BYTES (NONCE_BYTES)
    ) u_rewrite (
        .nonce_in    (nonce_q),
        .len_in      (len_q),
        .iport_in    (iport_q),
        .cached      (cached_q),
        .kind_out    (rw_kind),
        .nonce_out   (rw_nonce),
        .len_out     (rw_len),
        .content_out (rw_content),
        .eport_out   (rw_eport)
    );

    // outputs per state
    always_comb begin
        out_valid   = 1'b0;
        out_kind    = kind_q;
        out_key     = key_q;
        out_nonce   = nonce_q;
        out_len     = len_q;
        out_content = content_q;
        out_iport   = iport_q;
        out_eport   = eport_q;
        unique case (st_q)
            ST_IDLE: begin
                out_valid = 1'b0;
            end
            ST_PASS_RESP, ST_FWD_REQ: begin
                out_valid = 1'b1;
            end
            ST_REPLY: begin
                out_valid   = 1'b1;
                out_kind    = rw_kind;
                out_nonce   = rw_nonce;
                out_len     = rw_len;
                out_content = rw_content;
                out_eport   = rw_eport;
            end
            default: out_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/cc_checker.sv
module cc_checker #(
    parameter int KEY_W       = 32,
    parameter int DATA_W      = 64,
    parameter int LEN_W       = 16,
    parameter int PORT_W      = 4,
    parameter int NONCE_BYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_kind,
    input logic [KEY_W-1:0]  in_key,
    input logic              in_nonce,
    input logic [LEN_W-1:0]  in_len,
    input logic [DATA_W-1:0] in_content,
    input logic [PORT_W-1:0] in_iport,
    input logic [PORT_W-1:0] in_eport,
    input logic              out_valid,
    input logic              out_kind,
    input logic [KEY_W-1:0]  out_key,
    input logic              out_nonce,
    input logic [LEN_W-1:0]  out_len,
    input logic [DATA_W-1:0] out_content,
    input logic [PORT_W-1:0] out_iport,
    input logic [PORT_W-1:0] out_eport
);
    AST_ONE_OUT_PER_IN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid)); // R2

    AST_RESP_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind) |=> (out_kind && out_key == $past(in_key)
            && out_len == $past(in_len) && out_content == $past(in_content)
            && out_eport == $past(in_eport))); // R3

    AST_KEY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_key == $past(in_key) && out_iport == $past(in_iport))); // R4

    AST_REPLY_NO_NONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_kind) |=> (out_kind |-> !out_nonce)); // R5

    AST_REPLY_REFLECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_kind) |=> (out_kind |-> out_eport == out_iport)); // R6

    AST_MISS_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_kind) |=> (!out_kind |-> (out_len == $past(in_len)
            && out_eport == $past(in_eport) && out_nonce == $past(in_nonce)))); // R7
endmodule

bind content_cache_rewrite cc_checker #(
    .KEY_W       (KEY_W),
    .DATA_W      (DATA_W),
    .LEN_W       (LEN_W),
    .PORT_W      (PORT_W),
    .NONCE_BYTES (NONCE_BYTES)
) u_chk (.*);

// File: tb/content_cache_rewrite_bench.sv
module content_cache_rewrite_bench;
    localparam int CAP = 16;
    localparam int NB  = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_kind, in_nonce;
    logic [31:0] in_key;
    logic [15:0] in_len;
    logic [63:0] in_content;
    logic [3:0]  in_iport, in_eport;
    logic        out_valid, out_kind, out_nonce;
    logic [31:0] out_key;
    logic [15:0] out_len;
    logic [63:0] out_content;
    logic [3:0]  out_iport, out_eport;

    always #5 clk = ~clk;

    content_cache_rewrite #(.CAPACITY(CAP), .NONCE_BYTES(NB)) u_content_cache_rewrite (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_kind(in_kind), .in_key(in_key), .in_nonce(in_nonce),
        .in_len(in_len), .in_content(in_content), .in_iport(in_iport), .in_eport(in_eport),
        .out_valid(out_valid), .out_kind(out_kind), .out_key(out_key), .out_nonce(out_nonce),
        .out_len(out_len), .out_content(out_content), .out_iport(out_iport), .out_eport(out_eport)
    );

    int total = 0;
    int bad   = 0;

    // behavioural cache model
    bit          m_ok  [int];
    logic [31:0] m_key [int];
    logic [63:0] m_dat [int];

    // expected output for the descriptor driven last cycle
    bit          e_valid, e_kind, e_nonce;
    logic [31:0] e_key;
    logic [15:0] e_len;
    logic [63:0] e_content;
    logic [3:0]  e_iport, e_eport;
    string       e_tag;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare();
        chk(out_valid === e_valid, "R2 valid", 64'(out_valid), 64'(e_valid));
        if (e_valid) begin
            chk(out_kind === e_kind, {e_tag, " kind"}, 64'(out_kind), 64'(e_kind));
            chk(out_key === e_key, {e_tag, " key"}, 64'(out_key), 64'(e_key));
            chk(out_nonce === e_nonce, {e_tag, " nonce"}, 64'(out_nonce), 64'(e_nonce));
            chk(out_len === e_len, {e_tag, " len"}, 64'(out_len), 64'(e_len));
            chk(out_content === e_content, {e_tag, " content"}, out_content, e_content);
            chk(out_iport === e_iport, {e_tag, " iport"}, 64'(out_iport), 64'(e_iport));
            chk(out_eport === e_eport, {e_tag, " eport"}, 64'(out_eport), 64'(e_eport));
        end
    endtask

    task automatic step(input bit v, input bit k, input logic [31:0] key, input bit nz,
                        input logic [15:0] len, input logic [63:0] c,
                        input logic [3:0] ip, input logic [3:0] ep);
        int slot;
        bit hit;
        @(negedge clk);
        compare();
        slot = int'(key % CAP);
        hit  = m_ok.exists(slot) && m_ok[slot] && (m_key[slot] == key);
        e_valid = v; e_kind = k; e_key = key; e_nonce = nz; e_len = len;
        e_content = c; e_iport = ip; e_eport = ep;
        if (k) e_tag = "R3 pass";
        else if (!hit) e_tag = (m_ok.exists(slot) && m_ok[slot]) ? "R8 collide-miss" : "R7 miss";
        else begin
            e_tag     = "R4/R5/R6 hit";
            e_kind    = 1'b1;
            e_nonce   = 1'b0;
            e_len     = len - (nz ? 16'(2 + NB) : 16'd0) + 16'd10;
            e_content = m_dat[slot];
            e_eport   = ip;
        end
        if (v && k) begin
            m_ok[slot] = 1'b1; m_key[slot] = key; m_dat[slot] = c;
        end
        in_valid = v; in_kind = k; in_key = key; in_nonce = nz; in_len = len;
        in_content = c; in_iport = ip; in_eport = ep;
    endtask

    initial begin : watchdog
        #2000000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        in_valid = 0; in_kind = 0; in_key = 0; in_nonce = 0; in_len = 0;
        in_content = 0; in_iport = 0; in_eport = 0;
        e_valid = 0; e_tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0, "R1 reset out_valid", 64'(out_valid), 64'd0);

        // R1: empty cache misses
        step(1, 0, 32'd5, 1, 16'd40, 64'h0, 4'd2, 4'd7);
        step(1, 0, 32'd21, 0, 16'd30, 64'h0, 4'd3, 4'd9);
        // R3: store, then R4/R5/R6 hits
        step(1, 1, 32'd5, 0, 16'd50, 64'hDEAD_BEEF_0123_4567, 4'd1, 4'd6);
        step(1, 0, 32'd5, 1, 16'd40, 64'h0, 4'd2, 4'd7);
        step(1, 0, 32'd5, 0, 16'd33, 64'h0, 4'd11, 4'd4);
        step(0, 0, 32'd0, 0, 16'd0, 64'h0, 4'd0, 4'd0);   // R2 gap
        // R8: collision overwrite (5 and 21 share a slot)
        step(1, 0, 32'd21, 1, 16'd44, 64'h0, 4'd8, 4'd1);
        step(1, 1, 32'd21, 1, 16'd60, 64'hA5A5_0000_FFFF_1234, 4'd0, 4'd3);
        step(1, 0, 32'd5, 1, 16'd40, 64'h0, 4'd2, 4'd7);
        step(1, 0, 32'd21, 1, 16'd44, 64'h0, 4'd8, 4'd1);
        // boundary lengths and other slots
        step(1, 1, 32'd15, 0, 16'd20, 64'hFFFF_FFFF_FFFF_FFFF, 4'd15, 4'd15);
        step(1, 0, 32'd15, 1, 16'(2 + NB), 64'h0, 4'd15, 4'd0);
        step(1, 0, 32'd0, 0, 16'd12, 64'h0, 4'd4, 4'd5);

        for (int i = 0; i < 2000; i++) begin
            step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                 32'($urandom_range(0, 3 * CAP)), $urandom_range(0, 1) == 1,
                 16'($urandom_range(2 + NB, 1500)), {$urandom, $urandom},
                 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)));
        end
        step(0, 0, 32'd0, 0, 16'd0, 64'h0, 4'd0, 4'd0);
        step(0, 0, 32'd0, 0, 16'd0, 64'h0, 4'd0, 4'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule